// File: doc/BRIEF.md
# Vectored Interrupt Controller

This block merges a set of interrupt request lines into one interrupt output toward a processor. A build-time mask marks each line as rising-edge sensitive or level sensitive. Requests pass through a two-flop synchroniser. When hardware capture is on, they latch into a status word. The status word is masked by an enable word to form the pending word. The block reports the lowest-numbered pending source as a vector. The output is raised when the master output enable allows it.

Software reaches eight 32-bit word registers over a simple single-cycle bus. Writes take effect on the clock edge, and reads return data combinationally. The byte address is divided by four to get the word index.

The word indices are as follows:

- 0: status
- 1: pending
- 2: enable
- 3: acknowledge
- 4: set-enable
- 5: clear-enable
- 6: vector
- 7: master control. Bit 0 gates the output and bit 1 turns on hardware capture.

Set-enable and clear-enable change single enable bits without a read-modify-write. Software may load status directly only while capture is off, which lets it raise test interrupts.

Top module: `vec_irq_ctrl`

## Requirements
- R1: After reset, irq_o is low, the status, enable and master control words read 0, and the vector reads 0xFFFFFFFF.
- R2: The pending word (index 1) always reads status AND enable.
- R3: The vector word (index 6) reads the index of the lowest set pending bit, or 0xFFFFFFFF when no bit is pending.
- R4: irq_o is high exactly when master control bit 0 is set and at least one pending bit is set.
- R5: With capture on (master control bit 1), a level-sensitive input that is high sets its status bit, and keeps setting it while high, so an acknowledge has no effect until the input falls.
- R6: With capture on, each rising edge of an edge-sensitive input sets its status bit once; an acknowledge while the input stays high clears the bit for good.
- R7: With capture off, inputs do not set status bits. The previous-sample state is still tracked, so an edge input already high when capture turns on is not captured.
- R8: A write to status (index 0) loads it while master control bit 1 is clear, and is ignored while it is set.
- R9: A write to acknowledge (index 3) clears the status bits where the written value has ones.
- R10: A write to set-enable (index 4) ORs the value into enable; a write to clear-enable (index 5) clears the enable bits where the value has ones. A write to enable (index 2) or master control (index 7) loads it directly.
- R11: Writes to pending and vector have no lasting effect; both are recomputed from status and enable.
- R12: Reads of acknowledge, set-enable and clear-enable return the last value written there. Accesses to word indices 8 and above, or with a nonzero value in address bits 1:0, read 0 and writes to them are ignored.
- R13: A request input that rises is seen in status on the third rising clock edge after the change and not before; edge-sensitive inputs are selected by ones in parameter EDGE_MASK.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | NUM_SRC | Asynchronous interrupt request lines |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | ADDR_W | Byte address of the register access |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i, combinational |
| irq_o | output | 1 | Interrupt toward the processor |

## Verification
Several properties are checked on every clock cycle:

- The vector is all ones exactly when nothing is pending, and otherwise names a pending bit with no lower pending bit.
- The output agrees with master bit 0 and the pending word.
- Acknowledge, set-enable and clear-enable change the bits they target.
- Status gains no bits while capture is off, and a status write never clears bits while capture is on.

Only the directed scenarios can show the following:

- the synchroniser latency;
- that an edge input is captured once per edge;
- that a level input survives an acknowledge while held high;
- that an edge already present when capture starts is not captured;
- the readback of the write-only offsets and the handling of out-of-range and misaligned addresses.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int unsigned NUM_REGS = 8;
  localparam int unsigned DATA_W   = 32;

  typedef enum logic [2:0] {
    REG_STAT  = 3'd0,
    REG_PEND  = 3'd1,
    REG_EN    = 3'd2,
    REG_ACK   = 3'd3,
    REG_SETEN = 3'd4,
    REG_CLREN = 3'd5,
    REG_VEC   = 3'd6,
    REG_MCTL  = 3'd7
  } reg_idx_e;

  localparam int unsigned MCTL_OUT_BIT = 0;
  localparam int unsigned MCTL_CAP_BIT = 1;
endpackage

// File: rtl/intc_sync.sv
module intc_sync #(
  parameter int unsigned W      = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
    end else begin
      stage_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/intc_capture.sv
module intc_capture #(
  parameter int unsigned    W         = 32,
  parameter logic [W-1:0]   EDGE_MASK = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] sync_i,
  input  logic         cap_en_i,
  output logic [W-1:0] set_o
);
  logic [W-1:0] prev_q;

  // previous sample tracked regardless of capture enable
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= sync_i;
  end

  for (genvar g = 0; g < W; g++) begin : g_src
    if (EDGE_MASK[g]) begin : g_edge
      assign set_o[g] = cap_en_i & sync_i[g] & ~prev_q[g];
    end else begin : g_level
      assign set_o[g] = cap_en_i & sync_i[g];
    end
  end
endmodule

// File: rtl/intc_prio_enc.sv
module intc_prio_enc #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] pend_i,
  output logic [31:0]  vec_o
);
  always_comb begin
    vec_o = '1;
    for (int i = W - 1; i >= 0; i--) begin
      if (pend_i[i]) vec_o = 32'(i);
    end
  end
endmodule

// File: rtl/vec_irq_ctrl.sv
module vec_irq_ctrl
  import intc_pkg::*;
#(
  parameter int unsigned        NUM_SRC     = 32,
  parameter logic [NUM_SRC-1:0] EDGE_MASK   = '0,
  parameter int unsigned        ADDR_W      = 8,
  parameter int unsigned        SYNC_STAGES = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] req_i,
  input  logic               wr_en_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [31:0]        wdata_i,
  output logic [31:0]        rdata_o,
  output logic               irq_o
);
  localparam int unsigned WORD_W = ADDR_W - 2;

  logic [WORD_W-1:0]  word_idx;
  logic               acc_ok;
  logic [NUM_REGS-1:0] wr_sel;

  logic [NUM_SRC-1:0] stat_q, stat_d;
  logic [NUM_SRC-1:0] en_q, en_d;
  logic [31:0]        mctl_q, ack_q, seten_q, clren_q;
  logic [NUM_SRC-1:0] pend;
  logic [31:0]        vec;
  logic [NUM_SRC-1:0] req_sync, cap_set;

  assign word_idx = addr_i[ADDR_W-1:2];
  assign acc_ok   = (addr_i[1:0] == 2'b00) && (word_idx < WORD_W'(NUM_REGS));

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_wsel
    assign wr_sel[r] = wr_en_i & acc_ok & (word_idx == WORD_W'(r));
  end

  intc_sync #(.W(NUM_SRC), .STAGES(SYNC_STAGES)) i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (req_i),
    .q_o   (req_sync)
  );

  intc_capture #(.W(NUM_SRC), .EDGE_MASK(EDGE_MASK)) i_capture (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .sync_i  (req_sync),
    .cap_en_i(mctl_q[MCTL_CAP_BIT]),
    .set_o   (cap_set)
  );

  // write first, then capture, so a held level input survives an acknowledge
  always_comb begin
    stat_d = stat_q;
    if (wr_sel[REG_STAT] && !mctl_q[MCTL_CAP_BIT]) stat_d = wdata_i[NUM_SRC-1:0];
    if (wr_sel[REG_ACK]) stat_d = stat_d & ~wdata_i[NUM_SRC-1:0];
    stat_d = stat_d | cap_set;
  end

  always_comb begin
    en_d = en_q;
    if (wr_sel[REG_EN])    en_d = wdata_i[NUM_SRC-1:0];
    if (wr_sel[REG_SETEN]) en_d = en_q | wdata_i[NUM_SRC-1:0];
    if (wr_sel[REG_CLREN]) en_d = en_q & ~wdata_i[NUM_SRC-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_q  <= '0;
      en_q    <= '0;
      mctl_q  <= '0;
      ack_q   <= '0;
      seten_q <= '0;
      clren_q <= '0;
    end else begin
      stat_q <= stat_d;
      en_q   <= en_d;
      if (wr_sel[REG_MCTL])  mctl_q  <= wdata_i;
      if (wr_sel[REG_ACK])   ack_q   <= wdata_i;
      if (wr_sel[REG_SETEN]) seten_q <= wdata_i;
      if (wr_sel[REG_CLREN]) clren_q <= wdata_i;
    end
  end

  assign pend = stat_q & en_q;

  intc_prio_enc #(.W(NUM_SRC)) i_prio (
    .pend_i(pend),
    .vec_o (vec)
  );

  assign irq_o = mctl_q[MCTL_OUT_BIT] & (|pend);

  always_comb begin
    rdata_o = '0;
    if (acc_ok) begin
      unique case (word_idx[2:0])
        REG_STAT:  rdata_o = 32'(stat_q);
        REG_PEND:  rdata_o = 32'(pend);
        REG_EN:    rdata_o = 32'(en_q);
        REG_ACK:   rdata_o = ack_q;
        REG_SETEN: rdata_o = seten_q;
        REG_CLREN: rdata_o = clren_q;
        REG_VEC:   rdata_o = vec;
        REG_MCTL:  rdata_o = mctl_q;
        default:   rdata_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/vec_irq_ctrl_chk.sv
module vec_irq_ctrl_chk
  import intc_pkg::*;
#(
  parameter int unsigned NUM_SRC = 32,
  parameter int unsigned ADDR_W  = 8
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               wr_en_i,
  input logic [ADDR_W-1:0]  addr_i,
  input logic [31:0]        wdata_i,
  input logic               irq_o,
  input logic [NUM_SRC-1:0] stat_q,
  input logic [NUM_SRC-1:0] en_q,
  input logic [31:0]        mctl_q,
  input logic [NUM_SRC-1:0] pend,
  input logic [31:0]        vec
);
  localparam int unsigned IDX_W = $clog2(NUM_SRC);

  logic wr_stat, wr_ack, wr_set, wr_clr;
  assign wr_stat = wr_en_i && (addr_i == ADDR_W'(4 * REG_STAT));
  assign wr_ack  = wr_en_i && (addr_i == ADDR_W'(4 * REG_ACK));
  assign wr_set  = wr_en_i && (addr_i == ADDR_W'(4 * REG_SETEN));
  assign wr_clr  = wr_en_i && (addr_i == ADDR_W'(4 * REG_CLREN));

  // R3
  a_r3_vec_none: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend == '0) == (vec == '1));
  a_r3_vec_lowest: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend != '0) |-> (pend[vec[IDX_W-1:0]] &&
      ((pend & ((NUM_SRC'(1) << vec[IDX_W-1:0]) - NUM_SRC'(1))) == '0)));
  // R4
  a_r4_irq_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mctl_q[MCTL_OUT_BIT] |-> !irq_o);
  a_r4_irq_raised: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mctl_q[MCTL_OUT_BIT] && (pend != '0)) |-> irq_o);
  // R7
  a_r7_no_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mctl_q[MCTL_CAP_BIT] && !wr_stat) |=> ((stat_q & ~$past(stat_q)) == '0));
  // R8
  a_r8_stat_locked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_stat && mctl_q[MCTL_CAP_BIT]) |=> (($past(stat_q) & ~stat_q) == '0));
  // R9
  a_r9_ack_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_ack && !mctl_q[MCTL_CAP_BIT]) |=> ((stat_q & $past(wdata_i[NUM_SRC-1:0])) == '0));
  // R10
  a_r10_set_en: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_set |=> ((en_q & $past(wdata_i[NUM_SRC-1:0])) == $past(wdata_i[NUM_SRC-1:0])));
  a_r10_clr_en: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_clr |=> ((en_q & $past(wdata_i[NUM_SRC-1:0])) == '0));
endmodule

bind vec_irq_ctrl vec_irq_ctrl_chk #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W)) i_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .wr_en_i(wr_en_i),
  .addr_i (addr_i),
  .wdata_i(wdata_i),
  .irq_o  (irq_o),
  .stat_q (stat_q),
  .en_q   (en_q),
  .mctl_q (mctl_q),
  .pend   (pend),
  .vec    (vec)
);

// File: tb/test_vec_irq_ctrl.sv
module test_vec_irq_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] EDGES = 32'hFFFF_0000;
  localparam int A_STAT = 0, A_PEND = 4, A_EN = 8, A_ACK = 12,
                 A_SET = 16, A_CLR = 20, A_VEC = 24, A_MCTL = 28;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] req = '0;
  logic        wr_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  vec_irq_ctrl #(.NUM_SRC(32), .EDGE_MASK(EDGES), .ADDR_W(8)) i_vec_irq_ctrl (
    .clk_i  (clk),
    .rst_ni (rst_n),
    .req_i  (req),
    .wr_en_i(wr_en),
    .addr_i (addr),
    .wdata_i(wdata),
    .rdata_o(rdata),
    .irq_o  (irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    addr = 8'(a); wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    addr = 8'(a);
    #1;
    d = rdata;
  endtask

  task automatic rchk(input string tag, input int a, input logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    chk(tag, d, exp);
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R1 irq", {31'd0, irq}, 32'd0);
    rchk("R1 status", A_STAT, 32'd0);
    rchk("R1 enable", A_EN, 32'd0);
    rchk("R1 mctl", A_MCTL, 32'd0);
    rchk("R1 vector", A_VEC, 32'hFFFF_FFFF);
  endtask

  task automatic t_sw_status;
    wr(A_STAT, 32'h0000_0A08);
    rchk("R8 status load", A_STAT, 32'h0000_0A08);
    rchk("R2 pending masked", A_PEND, 32'd0);
    wr(A_SET, 32'h0000_0A00);
    rchk("R10 set-enable", A_EN, 32'h0000_0A00);
    rchk("R2 pending", A_PEND, 32'h0000_0A00);
    rchk("R3 vector", A_VEC, 32'd9);
    chk("R4 irq gated", {31'd0, irq}, 32'd0);
    wr(A_MCTL, 32'h1);
    chk("R4 irq on", {31'd0, irq}, 32'd1);
    wr(A_CLR, 32'h0000_0200);
    rchk("R10 clear-enable", A_EN, 32'h0000_0800);
    rchk("R3 vector next", A_VEC, 32'd11);
    rchk("R12 set readback", A_SET, 32'h0000_0A00);
    rchk("R12 clr readback", A_CLR, 32'h0000_0200);
    wr(A_ACK, 32'h0000_0800);
    rchk("R9 ack", A_STAT, 32'h0000_0208);
    rchk("R12 ack readback", A_ACK, 32'h0000_0800);
    rchk("R3 vector none", A_VEC, 32'hFFFF_FFFF);
    chk("R4 irq off", {31'd0, irq}, 32'd0);
  endtask

  task automatic t_reg_misc;
    wr(A_STAT, 32'h4);
    wr(A_EN, 32'h7);
    rchk("R10 enable load", A_EN, 32'h7);
    wr(A_PEND, 32'hFFFF);
    rchk("R11 pending write", A_PEND, 32'h4);
    wr(A_VEC, 32'd5);
    rchk("R11 vector write", A_VEC, 32'd2);
    wr(64, 32'hFF);
    rchk("R12 out of range read", 64, 32'd0);
    rchk("R12 out of range write", A_STAT, 32'h4);
    wr(A_EN + 1, 32'h0);
    rchk("R12 misaligned write", A_EN, 32'h7);
    rchk("R12 misaligned read", A_EN + 1, 32'd0);
    wr(A_MCTL, 32'h0000_0005);
    rchk("R10 mctl load", A_MCTL, 32'h5);
    wr(A_STAT, 32'h0);
    wr(A_EN, 32'h0);
    wr(A_MCTL, 32'h0);
  endtask

  task automatic t_prio;
    wr(A_STAT, 32'h8010_0000);
    wr(A_EN, 32'hFFFF_FFFF);
    rchk("R3 lowest of two", A_VEC, 32'd20);
    wr(A_ACK, 32'h0010_0000);
    rchk("R3 top bit", A_VEC, 32'd31);
    wr(A_ACK, 32'hFFFF_FFFF);
  endtask

  task automatic t_lock;
    wr(A_MCTL, 32'h2);
    wr(A_STAT, 32'h0000_FFFF);
    rchk("R8 status locked", A_STAT, 32'd0);
  endtask

  task automatic t_level;
    wr(A_MCTL, 32'h3);
    @(negedge clk);
    req[3] = 1'b1;
    wait_cyc(2);
    rchk("R13 not before third edge", A_STAT, 32'd0);
    wait_cyc(1);
    rchk("R13 third edge", A_STAT, 32'h8);
    chk("R4 irq level", {31'd0, irq}, 32'd1);
    wr(A_ACK, 32'h8);
    rchk("R5 level survives ack", A_STAT, 32'h8);
    req[3] = 1'b0;
    wait_cyc(4);
    wr(A_ACK, 32'h8);
    rchk("R5 cleared after drop", A_STAT, 32'd0);
    chk("R5 irq low", {31'd0, irq}, 32'd0);
  endtask

  task automatic t_edge;
    @(negedge clk);
    req[20] = 1'b1;
    wait_cyc(4);
    rchk("R6 edge set", A_STAT, 32'h0010_0000);
    rchk("R6 vector", A_VEC, 32'd20);
    wr(A_ACK, 32'h0010_0000);
    wait_cyc(4);
    rchk("R6 once per edge", A_STAT, 32'd0);
    req[20] = 1'b0;
    wait_cyc(4);
    req[20] = 1'b1;
    wait_cyc(4);
    rchk("R6 second edge", A_STAT, 32'h0010_0000);
    wr(A_ACK, 32'h0010_0000);
    req[20] = 1'b0;
    wait_cyc(4);
  endtask

  task automatic t_no_capture;
    wr(A_MCTL, 32'h1);
    @(negedge clk);
    req[2] = 1'b1;
    req[17] = 1'b1;
    wait_cyc(5);
    rchk("R7 no capture", A_STAT, 32'd0);
    chk("R7 irq low", {31'd0, irq}, 32'd0);
    wr(A_MCTL, 32'h3);
    wait_cyc(2);
    rchk("R7 held edge not captured", A_STAT, 32'h4);
    req = '0;
    wait_cyc(4);
    wr(A_ACK, 32'hFFFF_FFFF);
    rchk("R9 ack all", A_STAT, 32'd0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    wait_cyc(3);
    rst_n = 1'b1;
    wait_cyc(1);
    t_reset();
    t_sw_status();
    t_reg_misc();
    t_prio();
    t_lock();
    t_level();
    t_edge();
    t_no_capture();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule